// File: doc/BRIEF.md
# Pipeline Stage Gain-Calibration Sequencer

This block is the digital controller for the foreground gain calibration of a pipelined converter. The first three residue stages each have a feedback capacitor bank that trims their closed-loop gain. A single start pulse makes the controller visit the stages from the last one back to the first. For each stage it searches the 7-bit trim code by successive approximation and judges every trial with one comparator decision.

While a stage is being trimmed, its mode output places it in calibration mode, where it samples one eighth of the reference. The stages behind it that are already trimmed go to ideal mode, where they subtract three eighths of the reference and gain by four. The stages in front of it stay in normal mode. If the gain under test is exactly four, the chain output lands on half the reference. The comparator input tells the controller whether the output fell below that target. The whole search takes a fixed 168 cycles. After that the three codes stay in place for normal conversion.

Top module: `gcal_seq`

## Requirements
- R1: After a synchronous reset, every trim code reads 7'b1000000 (64), busy and done are low, and every stage mode reads normal (2'b00).
- R2: A start pulse seen while idle is taken at that clock edge. From the next cycle busy is high, and the stage with the highest index (stage 3, mode field bits [5:4]) is in calibration mode.
- R3: Stage modes are 2-bit fields, stage k at bits [2k-1:2k-2]: 2'b00 normal, 2'b01 calibration, 2'b10 ideal. Stages are calibrated in the order 3, 2, 1, each for 56 cycles. The stages above the one in calibration read ideal, and the stages below it read normal.
- R4: Each bit takes a trial of 8 cycles, from MSB to LSB. The trial code is the code found so far with the current bit set to 1 and all lower bits 0, so each stage begins at 64. The comparator is sampled only on the eighth cycle of a trial.
- R5: A comparator result of 1 (residue below target) keeps the trial bit at 1. A result of 0 clears it.
- R6: For a stage whose chain output rises with its code, the final code is the largest code whose output is still below the target. It is 0 if no code is below the target and 127 if every code is.
- R7: Done is high for exactly one cycle, 168 cycles after the edge that took start. Busy falls in that same cycle.
- R8: A start pulse while busy has no effect: the timing and the results match a run without it.
- R9: While idle, the trim codes hold their values whatever the comparator does, until the next accepted start.
- R10: A reset during a run aborts it and returns the block to the state in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse for a full calibration |
| cmp_low_i | input | 1 | Comparator: 1 = chain output below the half-reference target |
| mode_o | output | 2*NUM_STAGES | Per-stage mode fields (normal, calibration, ideal) |
| trim_o | output | NUM_STAGES*CODE_W | Per-stage trim codes, stage k at bits [7k-1:7k-7] |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle pulse when stage 1 is finished |

## Verification
The bench models each stage as a linear chain output over its code, with its own threshold. The model gives a correct comparator answer only when the mode pattern is correct, so a wrong stage order or a wrong ideal/normal pattern shows up as wrong final codes. Thresholds of 0, 1, 64, 65, 127 and 128 target the edges of the search. A design that mishandles the first or last bit, or that inverts the decision, ends one or more codes at the wrong value. Exact checks on the 168th cycle and on the mode change at cycle 56 catch an off-by-one in the trial timer. A start pulse in the middle of a run, a comparator that toggles while idle, and a reset in the middle of a run show whether the block restarts, drifts or fails to clear.

// File: rtl/gcal_pkg.sv
package gcal_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'b00,
      MODE_CAL    = 2'b01,
      MODE_IDEAL  = 2'b10
   } stage_mode_e;

endpackage

// File: rtl/gcal_trial_timer.sv
// Cycle counter inside one successive-approximation trial.
module gcal_trial_timer #(
   parameter int TRIAL_CYC = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic clear_i,
   input  logic run_i,
   output logic last_o
);
   localparam int CNT_W = (TRIAL_CYC > 1) ? $clog2(TRIAL_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TRIAL_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clear_i) begin
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/gcal_sar_reg.sv
// One stage's trim-code register with the successive-approximation bit update.
module gcal_sar_reg #(
   parameter int CODE_W = 7,
   parameter int BIT_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic              latch_i,
   input  logic [BIT_W-1:0]  bit_i,
   input  logic              keep_i,
   output logic [CODE_W-1:0] code_o
);
   localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk) begin
      if (rst || load_i) begin
         code_q <= MID;
      end else if (latch_i) begin
         code_q[bit_i] <= keep_i;
         if (bit_i != '0) begin
            code_q[bit_i - 1'b1] <= 1'b1;
         end
      end
   end

   assign code_o = code_q;
endmodule

// File: rtl/gcal_seq.sv
// Foreground gain-calibration sequencer: walks stages from last to first,
// running a successive-approximation search on each stage's trim code.
module gcal_seq #(
   parameter int NUM_STAGES = 3,
   parameter int CODE_W     = 7,
   parameter int TRIAL_CYC  = 8
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           start_i,
   input  logic                           cmp_low_i,
   output logic [2*NUM_STAGES-1:0]        mode_o,
   output logic [NUM_STAGES*CODE_W-1:0]   trim_o,
   output logic                           busy_o,
   output logic                           done_o
);
   import gcal_pkg::*;

   localparam int BIT_W = $clog2(CODE_W);
   localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;
   localparam logic [STG_W-1:0] STG_TOP = STG_W'(NUM_STAGES - 1);
   localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(CODE_W - 1);

   if (NUM_STAGES < 1 || CODE_W < 2 || TRIAL_CYC < 2) begin : g_bad_param
      $error("gcal_seq: NUM_STAGES>=1, CODE_W>=2 and TRIAL_CYC>=2 required");
   end

   logic             busy_q, done_q;
   logic [STG_W-1:0] stage_q;
   logic [BIT_W-1:0] bit_q;
   logic             trial_end, accept, sample, last_bit, last_stage;

   assign accept     = start_i & ~busy_q;
   assign sample     = busy_q & trial_end;
   assign last_bit   = (bit_q == '0);
   assign last_stage = (stage_q == '0);

   gcal_trial_timer #(.TRIAL_CYC(TRIAL_CYC)) i_timer (
      .clk     (clk),
      .rst     (rst),
      .clear_i (accept),
      .run_i   (busy_q),
      .last_o  (trial_end)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         stage_q <= STG_TOP;
         bit_q   <= BIT_TOP;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            stage_q <= STG_TOP;
            bit_q   <= BIT_TOP;
         end else if (sample) begin
            if (last_bit) begin
               bit_q <= BIT_TOP;
               if (last_stage) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  stage_q <= stage_q - 1'b1;
               end
            end else begin
               bit_q <= bit_q - 1'b1;
            end
         end
      end
   end

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      logic load, latch;
      logic [CODE_W-1:0] code;

      if (s == NUM_STAGES - 1) begin : g_first
         assign load = accept;
      end else begin : g_later
         assign load = sample & last_bit & ~last_stage & (stage_q == STG_W'(s + 1));
      end
      assign latch = sample & (stage_q == STG_W'(s));

      gcal_sar_reg #(.CODE_W(CODE_W), .BIT_W(BIT_W)) i_sar (
         .clk     (clk),
         .rst     (rst),
         .load_i  (load),
         .latch_i (latch),
         .bit_i   (bit_q),
         .keep_i  (cmp_low_i),
         .code_o  (code)
      );

      assign trim_o[s*CODE_W +: CODE_W] = code;
      assign mode_o[2*s +: 2] =
         !busy_q                    ? MODE_NORMAL :
         (stage_q == STG_W'(s))     ? MODE_CAL    :
         (STG_W'(s) > stage_q)      ? MODE_IDEAL  : MODE_NORMAL;
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
endmodule

module gcal_seq_chk #(
   parameter int NUM_STAGES = 3,
   parameter int CODE_W     = 7,
   parameter int TRIAL_CYC  = 8
) (
   input logic                         clk,
   input logic                         rst,
   input logic                         start_i,
   input logic [2*NUM_STAGES-1:0]      mode_o,
   input logic [NUM_STAGES*CODE_W-1:0] trim_o,
   input logic                         busy_o,
   input logic                         done_o
);
   localparam int TOTAL = NUM_STAGES * CODE_W * TRIAL_CYC;
   localparam int CNT_W = $clog2(TOTAL + 1) + 1;
   localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

   logic [CNT_W-1:0] busy_cnt;
   logic [NUM_STAGES:0] cal_cnt;

   always_ff @(posedge clk) begin
      if (rst) busy_cnt <= '0;
      else if (start_i && !busy_o) busy_cnt <= '0;
      else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
   end

   always_comb begin
      cal_cnt = '0;
      for (int s = 0; s < NUM_STAGES; s++) begin
         if (mode_o[2*s +: 2] == gcal_pkg::MODE_CAL) cal_cnt = cal_cnt + 1'b1;
      end
   end

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> !busy_o && !done_o && mode_o == '0 && trim_o == {NUM_STAGES{MID}});
   // R2
   start_taken_chk: assert property (@(posedge clk) disable iff (rst)
      start_i && !busy_o |=> busy_o);
   // R3
   one_cal_stage_chk: assert property (@(posedge clk) disable iff (rst)
      cal_cnt == {{NUM_STAGES{1'b0}}, busy_o});
   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);
   // R7
   done_budget_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |-> !busy_o && busy_cnt == CNT_W'(TOTAL));
   // R8
   start_busy_chk: assert property (@(posedge clk) disable iff (rst)
      busy_o && start_i && busy_cnt != CNT_W'(TOTAL - 1) |=> busy_o && busy_cnt == $past(busy_cnt) + 1'b1);
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !busy_o && !start_i |=> $stable(trim_o));
endmodule

bind gcal_seq gcal_seq_chk #(
   .NUM_STAGES (NUM_STAGES),
   .CODE_W     (CODE_W),
   .TRIAL_CYC  (TRIAL_CYC)
) i_gcal_seq_chk (
   .clk     (clk),
   .rst     (rst),
   .start_i (start_i),
   .mode_o  (mode_o),
   .trim_o  (trim_o),
   .busy_o  (busy_o),
   .done_o  (done_o)
);

// File: tb/test_gcal_seq.sv
module test_gcal_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 3;
   localparam int CW = 7;
   localparam int TOTAL = 168;
   localparam int NVEC = 5;
   // thresholds per stage {stage3, stage2, stage1}
   localparam logic [23:0] VEC [NVEC] = '{
      {8'd65,  8'd64,  8'd63},
      {8'd0,   8'd128, 8'd1},
      {8'd100, 8'd17,  8'd90},
      {8'd127, 8'd2,   8'd44},
      {8'd33,  8'd120, 8'd77}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic cmp_low;
   logic [2*NS-1:0] mode;
   logic [NS*CW-1:0] trim;
   logic busy, done;

   logic [7:0] thr [NS];
   logic ovr_en = 1'b0;
   logic ovr_val = 1'b0;
   logic model_low;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gcal_seq i_gcal_seq (
      .clk(clk), .rst(rst), .start_i(start), .cmp_low_i(cmp_low),
      .mode_o(mode), .trim_o(trim), .busy_o(busy), .done_o(done)
   );

   // Behavioural chain: output of the stage in calibration rises with its code;
   // below target when code < threshold, valid only with a correct mode pattern.
   always_comb begin
      int cal;
      bit ok;
      cal = -1;
      ok = 1'b1;
      for (int s = 0; s < NS; s++) if (mode[2*s +: 2] == 2'b01) cal = s;
      for (int s = 0; s < NS; s++) begin
         if (cal >= 0 && s > cal && mode[2*s +: 2] != 2'b10) ok = 1'b0;
         if (cal >= 0 && s < cal && mode[2*s +: 2] != 2'b00) ok = 1'b0;
      end
      if (cal >= 0 && ok) model_low = ({1'b0, trim[cal*CW +: CW]} < thr[cal]);
      else model_low = 1'b1;
   end
   assign cmp_low = ovr_en ? ovr_val : model_low;

   function automatic int exp_code(int t);
      return (t == 0) ? 0 : ((t > 127) ? 127 : t - 1);
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic run_cal(input logic [23:0] v, input bit pulse_mid);
      int bad_busy;
      bad_busy = 0;
      thr[2] = v[23:16]; thr[1] = v[15:8]; thr[0] = v[7:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R2: start taken at the previous edge
      chk(busy == 1'b1 && mode == 6'b010000, "R2", "busy/mode after start",
          {busy, mode}, {1'b1, 6'b010000});
      for (int cyc = 1; cyc <= TOTAL; cyc++) begin
         if (pulse_mid && cyc == 30) start = 1'b1;
         if (pulse_mid && cyc == 31) start = 1'b0;
         @(negedge clk);
         if (cyc < TOTAL && (busy !== 1'b1 || done !== 1'b0)) bad_busy++;
         if (cyc == 4) begin
            // R4: first trial code of stage 3 is 64
            chk(trim[14 +: 7] == 7'd64, "R4", "stage3 first trial", trim[14 +: 7], 64);
         end
         if (cyc == 9) begin
            // R5: below target keeps the MSB
            chk(trim[14 +: 7] == ((thr[2] > 64) ? 7'd96 : 7'd32), "R5", "stage3 second trial",
                trim[14 +: 7], (thr[2] > 64) ? 96 : 32);
         end
         if (cyc == 55) chk(mode == 6'b010000, "R3", "mode at cycle 55", mode, 6'b010000);
         if (cyc == 56) begin
            chk(mode == 6'b100100, "R3", "mode at cycle 56", mode, 6'b100100);
            chk(trim[7 +: 7] == 7'd64, "R4", "stage2 first trial", trim[7 +: 7], 64);
         end
         if (cyc == 120) chk(mode == 6'b101001, "R3", "mode at cycle 120", mode, 6'b101001);
         if (cyc == TOTAL)
            chk(done == 1'b1 && busy == 1'b0, "R7", "done/busy at cycle 168",
                {done, busy}, 2'b10);
      end
      chk(bad_busy == 0, pulse_mid ? "R8" : "R7", "cycles with busy low or early done", bad_busy, 0);
      @(negedge clk);
      chk(done == 1'b0 && mode == '0, "R7", "done width / modes after run", {done, mode}, 0);
      for (int s = 0; s < NS; s++)
         chk(trim[s*CW +: CW] == CW'(exp_code(thr[s])), "R6", $sformatf("final code stage%0d", s + 1),
             trim[s*CW +: CW], exp_code(thr[s]));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL R7 watchdog: actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [NS*CW-1:0] held;
      thr[0] = 8'd0; thr[1] = 8'd0; thr[2] = 8'd0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1
      chk(trim == {NS{7'd64}} && !busy && !done && mode == '0, "R1", "reset state",
          trim, {NS{7'd64}});

      for (int i = 0; i < NVEC; i++) run_cal(VEC[i], 1'b0);
      for (int i = 0; i < 2; i++)
         run_cal({8'($urandom_range(0, 128)), 8'($urandom_range(0, 128)),
                  8'($urandom_range(0, 128))}, 1'b0);

      // R8: start pulse in the middle of a run
      run_cal({8'd70, 8'd9, 8'd111}, 1'b1);

      // R9: idle, comparator toggling, codes hold
      held = trim;
      ovr_en = 1'b1;
      for (int i = 0; i < 20; i++) begin
         ovr_val = i[0];
         @(negedge clk);
      end
      ovr_en = 1'b0;
      chk(trim == held && !busy, "R9", "codes while idle", trim, held);

      // R10: reset in the middle of a run
      thr[2] = 8'd5; thr[1] = 8'd5; thr[0] = 8'd5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (70) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(trim == {NS{7'd64}} && !busy && !done && mode == '0, "R10", "state after mid-run reset",
          trim, {NS{7'd64}});
      repeat (TOTAL) @(negedge clk);
      chk(!busy && !done && trim == {NS{7'd64}}, "R10", "no run resumes after reset",
          {busy, done}, 0);

      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule